// File: doc/BRIEF.md
# Cascadable Magnitude Comparator Array

This block compares two unsigned operand words and reports their ordering as three mutually exclusive flags: the first operand larger, both equal, or the first operand smaller. The comparison is split across a chain of small comparator slices, four bits each by default. Every slice handles its own group of bit pairs and, only when that group matches exactly, passes on the verdict it receives from the next less significant slice. The lowest slice in the chain is seeded with a fixed "equal" verdict, so two identical words come out equal.

The top level picks the number of slices from the operand width. If the width is not a multiple of the slice width, the unused upper bits are filled with zeros. Besides the three active-high flags, the top level drives two active-low summary outputs, one for equality and one for "first operand larger", for logic that expects low-true strobes. The block has no clock or state: the outputs follow the inputs through combinational logic only.

Top module: `magcmp_array`

## Requirements
- R1: `aGt` is 1 exactly when `opA` is greater than `opB`, both read as unsigned numbers.
- R2: `aEq` is 1 exactly when every bit of `opA` matches the bit of `opB` at the same position.
- R3: `aLt` is 1 exactly when `opA` is less than `opB`, both read as unsigned numbers.
- R4: For every input pair, exactly one of `aGt`, `aEq` and `aLt` is 1.
- R5: `eqN` is 0 when the operands are equal and 1 otherwise.
- R6: `gtN` is 0 when `opA` is greater than `opB` and 1 otherwise.
- R7: The most significant bit position where the operands differ decides the result, whatever the lower bits hold (for example 0x80 against 0x7F gives greater).
- R8: A slice whose own four bit pairs all match passes on the verdict of the slice below it (for example 0x35 against 0x34 and 0x34 against 0x35 are decided in the low slice). The lowest slice is seeded with "equal", so equal words give `aEq` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First unsigned operand |
| opB | input | WIDTH | Second unsigned operand |
| aGt | output | 1 | High when opA > opB |
| aEq | output | 1 | High when opA == opB |
| aLt | output | 1 | High when opA < opB |
| eqN | output | 1 | Low when opA == opB |
| gtN | output | 1 | Low when opA > opB |

## Verification
The block holds no state, so the only internal "state" that can be wrong is a verdict on a link between slices. A wrong verdict shows at the ports in the same cycle, but only for operand pairs whose upper slices match and pass the bad value on. For that reason the bench drives every one of the 65536 operand pairs of the 8-bit configuration: a broken seed, a dropped pass-through or a wrong bit priority inside a slice is then always exposed by some pair. The active-low outputs are checked against the same reference. An inversion slip there shows at once on every vector.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;
  // Three-way verdict passed from slice to slice; exactly one bit set when legal.
  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } relT;

  localparam relT REL_EQUAL = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};
endpackage

// File: rtl/magcmp_slice.sv
module magcmp_slice
  import magcmp_pkg::*;
#(
  parameter int SLICE_BITS = 4
) (
  input  logic [SLICE_BITS-1:0] a,
  input  logic [SLICE_BITS-1:0] b,
  input  relT                   cascIn,
  output relT                   rel
);
  logic [SLICE_BITS-1:0] bitSame;
  logic                  decided;

  assign bitSame = ~(a ^ b);

  // Scan from the top bit down; the first mismatch settles the verdict.
  always_comb begin
    rel     = cascIn;
    decided = 1'b0;
    for (int i = SLICE_BITS - 1; i >= 0; i--) begin
      if (!decided && !bitSame[i]) begin
        decided = 1'b1;
        rel.gt  = a[i];
        rel.eq  = 1'b0;
        rel.lt  = b[i];
      end
    end
  end
endmodule

// File: rtl/magcmp_chain.sv
module magcmp_chain
  import magcmp_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int SLICE_BITS = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output relT              verdict
);
  localparam int NUM_SLICES = (WIDTH + SLICE_BITS - 1) / SLICE_BITS;
  localparam int PAD_WIDTH  = NUM_SLICES * SLICE_BITS;

  logic [PAD_WIDTH-1:0] padA;
  logic [PAD_WIDTH-1:0] padB;
  relT                  link [NUM_SLICES+1];

  always_comb begin
    padA            = '0;
    padB            = '0;
    padA[WIDTH-1:0] = opA;
    padB[WIDTH-1:0] = opB;
  end

  assign link[0] = REL_EQUAL;

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    magcmp_slice #(.SLICE_BITS(SLICE_BITS)) slice_i (
      .a      (padA[s*SLICE_BITS +: SLICE_BITS]),
      .b      (padB[s*SLICE_BITS +: SLICE_BITS]),
      .cascIn (link[s]),
      .rel    (link[s+1])
    );
  end

  assign verdict = link[NUM_SLICES];
endmodule

// File: rtl/magcmp_array.sv
module magcmp_array
  import magcmp_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int SLICE_BITS = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             aGt,
  output logic             aEq,
  output logic             aLt,
  output logic             eqN,
  output logic             gtN
);
  relT verdict;

  magcmp_chain #(.WIDTH(WIDTH), .SLICE_BITS(SLICE_BITS)) chain_i (
    .opA     (opA),
    .opB     (opB),
    .verdict (verdict)
  );

  assign aGt = verdict.gt;
  assign aEq = verdict.eq;
  assign aLt = verdict.lt;
  assign eqN = ~verdict.eq;
  assign gtN = ~verdict.gt;
endmodule

// File: rtl/magcmp_array_chk.sv
module magcmp_array_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             aGt,
  input logic             aEq,
  input logic             aLt,
  input logic             eqN,
  input logic             gtN
);
  logic known;
  assign known = !$isunknown({opA, opB, aGt, aEq, aLt, eqN, gtN});

  always_comb begin
    if (known) begin
      a_r1_gt_matches: assert (aGt == (opA > opB));
      a_r2_eq_matches: assert (aEq == (opA == opB));
      a_r3_lt_matches: assert (aLt == (opA < opB));
      a_r4_one_flag: assert ($countones({aGt, aEq, aLt}) == 1);
      a_r5_eqn_low_true: assert (eqN == !aEq);
      a_r6_gtn_low_true: assert (gtN == !aGt);
    end
  end
endmodule

bind magcmp_array magcmp_array_chk #(.WIDTH(WIDTH)) chk_i (
  .opA (opA),
  .opB (opB),
  .aGt (aGt),
  .aEq (aEq),
  .aLt (aLt),
  .eqN (eqN),
  .gtN (gtN)
);

// File: tb/magcmp_array_tb_top.sv
module magcmp_array_tb_top;
  localparam int WIDTH = 8;
  localparam int LIMIT = 200000;

  logic             clk;
  logic             rstN;
  logic [WIDTH-1:0] opA;
  logic [WIDTH-1:0] opB;
  logic             aGt, aEq, aLt, eqN, gtN;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  magcmp_array #(.WIDTH(WIDTH), .SLICE_BITS(4)) dut_i (
    .opA (opA),
    .opB (opB),
    .aGt (aGt),
    .aEq (aEq),
    .aLt (aLt),
    .eqN (eqN),
    .gtN (gtN)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic expectBit(input string req, input logic actual, input logic expected,
                           input int va, input int vb);
    checks++;
    if (actual !== expected) begin
      failures++;
      $display("FAIL %s a=%0h b=%0h actual=%0b expected=%0b", req, va, vb, actual, expected);
    end
  endtask

  // Reference model: plain integer relations, evaluated per clock.
  task automatic applyAndCheck(input int va, input int vb);
    @(posedge clk);
    opA = WIDTH'(va);
    opB = WIDTH'(vb);
    @(negedge clk);
    expectBit("R1", aGt, va > vb, va, vb);
    expectBit("R2", aEq, va == vb, va, vb);
    expectBit("R3", aLt, va < vb, va, vb);
    expectBit("R4", logic'($countones({aGt, aEq, aLt}) == 1), 1'b1, va, vb);
    expectBit("R5", eqN, va != vb, va, vb);
    expectBit("R6", gtN, !(va > vb), va, vb);
  endtask

  initial begin
    opA  = '0;
    opB  = '0;
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // Reset state: zero operands read as equal (R2, R8 seed).
    expectBit("R2", aEq, 1'b1, 0, 0);
    expectBit("R8", aGt | aLt, 1'b0, 0, 0);
    // R7: top differing bit wins over all lower bits.
    applyAndCheck(8'h80, 8'h7F);
    expectBit("R7", aGt, 1'b1, 8'h80, 8'h7F);
    applyAndCheck(8'h08, 8'h07);
    expectBit("R7", aGt, 1'b1, 8'h08, 8'h07);
    // R8: equal upper slice defers to lower slice.
    applyAndCheck(8'h35, 8'h34);
    expectBit("R8", aGt, 1'b1, 8'h35, 8'h34);
    applyAndCheck(8'h34, 8'h35);
    expectBit("R8", aLt, 1'b1, 8'h34, 8'h35);
    applyAndCheck(8'hFF, 8'hFF);
    expectBit("R8", aEq, 1'b1, 8'hFF, 8'hFF);
    // Exhaustive sweep over all operand pairs.
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        applyAndCheck(a, b);
      end
    end
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule